// File: doc/BRIEF.md
# Bridge Register Block with Unlock

This block is the control register file of a bus bridge that gives a host access to the configuration space of exactly one downstream device. The host reaches it through a simple request/acknowledge register port. The low part of the address map holds a fixed 16-character identification string, an unlock register, two address-window registers, a pair of DMA window bounds and two enable bits. Software reads the identification string first. It then writes a magic key and waits until the unlock register reads 1, programs the windows, and finally sets the enables.

A second address range, a fixed distance above the register base, is the configuration window. Accesses there carry a target bus and device/function number. Only bus 0, device/function 0 is selected. For that target the access is passed to a device port, with one request outstanding at a time, and the host acknowledge waits for the device. Any other target answers at once: reads return all ones at the access width, and writes are dropped.

Top module: `bridge_regblk`

## Requirements
- R1: Offsets 0x00 to 0x0F read back a fixed 16-character ASCII string, character i at byte offset i. A wider read gathers consecutive characters little-endian. Read data is formed as (word >> 8*addr[1:0]) masked to the access size, where h_size is 0 for a byte, 1 for a halfword and 2 for a word.
- R2: Offset 0x18 reads 0 after reset and during the unlock wait. Writing any value other than 0x5A14A501 there leaves the bridge locked.
- R3: Writing 0x5A14A501 to offset 0x18 raises bridge_ready on the UNLOCK_CYC-th clock edge after the edge that accepts the write. From then on offset 0x18 reads 1, and the unlocked state holds until reset.
- R4: Offsets 0x20 and 0x24 are 32-bit window registers. They read back what was written and drive map_win0 and map_win1.
- R5: Offset 0x28 holds the DMA window start and offset 0x2C holds its end, driving dma_base and dma_limit. A write to the end register is clamped so that it never exceeds the start plus DMA_BYTES (32 KiB).
- R6: Offsets 0x14 and 0x34 are enable registers that keep only bit 0. They read back as that single bit and drive link_en and xfer_en.
- R7: A configuration-window access (0x200 to 0x2FF) to bus 0, device/function 0 raises d_req with d_offset = address minus 0x200, plus the access size, direction and write data. d_req holds stable until d_ack. h_ack follows on the next edge, carrying d_rdata masked to the access size for reads.
- R8: A configuration read to any other target returns 0xFF, 0xFFFF or 0xFFFFFFFF for a byte, halfword or word access, and raises no d_req.
- R9: A configuration write to any other target is discarded: no d_req is raised and the device sees nothing.
- R10: Every local access is acknowledged by a one-cycle h_ack pulse on the edge after acceptance. Unmapped offsets read 0, and every write returns 0 as read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Host request, held until h_ack |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | ADDR_W | Byte offset from the bridge register base |
| h_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| h_wdata | input | 32 | Write data, right-aligned |
| h_bus | input | 8 | Target bus number for configuration accesses |
| h_devfn | input | 8 | Target device/function for configuration accesses |
| h_ack | output | 1 | One-cycle completion pulse |
| h_rdata | output | 32 | Read data, valid with h_ack |
| d_req | output | 1 | Device port request, held until d_ack |
| d_write | output | 1 | Device access direction |
| d_offset | output | CFG_OFF_W | Offset into the device configuration space |
| d_size | output | 2 | Device access size |
| d_wdata | output | 32 | Device write data |
| d_ack | input | 1 | Device completion |
| d_rdata | input | 32 | Device read data, right-aligned |
| bridge_ready | output | 1 | Bridge unlocked |
| map_win0 | output | 32 | First address window |
| map_win1 | output | 32 | Second address window |
| dma_base | output | 32 | DMA window start |
| dma_limit | output | 32 | DMA window end |
| link_en | output | 1 | First enable bit |
| xfer_en | output | 1 | Second enable bit |

## Verification
Some rules are checked by assertions on every cycle. h_ack is always a single-cycle pulse and follows a device completion by exactly one edge. A device request never starts while one is open, and it never starts for a target other than bus 0, device/function 0. The request and its offset stay stable while unanswered. The unlocked flag only rises from the wait state and never drops, and a write to the DMA end always leaves it within the window size. Other behaviour can only be shown by the bench scenarios: the string contents, the lane and width formatting, the all-ones answers for other targets, the exact unlock delay, and the fact that a wrong key or a write to another target changes nothing at the ports.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   // all-ones value at the width of an access; size 3 is treated as a word
   function automatic logic [31:0] width_mask(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: width_mask = 32'h0000_00FF;
         SZ_HALF: width_mask = 32'h0000_FFFF;
         default: width_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

   // move the addressed lane to bit 0 and keep only the access width
   function automatic logic [31:0] lane_align(input logic [31:0] w,
                                              input logic [1:0]  lane,
                                              input logic [1:0]  sz);
      lane_align = (w >> {lane, 3'b000}) & width_mask(sz);
   endfunction

endpackage

// File: rtl/bridge_id_rom.sv
module bridge_id_rom #(
   parameter logic [127:0] ID_STR = "BRIDGE_CFG_ID_01"
) (
   input  logic [1:0]  widx,
   output logic [31:0] word
);
   localparam int NCHAR = 16;
   localparam int NWORD = NCHAR / 4;

   logic [NWORD-1:0][31:0] words;

   // character i of the string sits at byte offset i, little-endian in words
   for (genvar w = 0; w < NWORD; w++) begin : g_word
      for (genvar b = 0; b < 4; b++) begin : g_byte
         assign words[w][8*b +: 8] = ID_STR[8*NCHAR-1 - 8*(4*w+b) -: 8];
      end
   end

   assign word = words[widx];

endmodule

// File: rtl/bridge_unlock.sv
module bridge_unlock #(
   parameter int          UNLOCK_CYC = 4,
   parameter logic [31:0] KEY        = 32'h5A14_A501
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_wr,
   input  logic [31:0] key_data,
   output logic        unlocked
);
   logic pending;
   logic key_ok;

   assign key_ok = key_wr && (key_data == KEY) && !unlocked && !pending;

   if (UNLOCK_CYC == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pending  <= 1'b0;
            unlocked <= 1'b0;
         end else if (key_ok) begin
            pending  <= 1'b1;
         end else if (pending) begin
            pending  <= 1'b0;
            unlocked <= 1'b1;
         end
      end
   end else begin : g_count
      localparam int CW = $clog2(UNLOCK_CYC);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pending  <= 1'b0;
            unlocked <= 1'b0;
            cnt      <= '0;
         end else if (key_ok) begin
            pending  <= 1'b1;
            cnt      <= CW'(UNLOCK_CYC - 1);
         end else if (pending) begin
            if (cnt == '0) begin
               pending  <= 1'b0;
               unlocked <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R3: ready only rises out of the wait state
   p_rise_from_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(pending));

   // R3: once unlocked, stays unlocked
   p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      unlocked |=> unlocked);

endmodule

// File: rtl/bridge_cfg_port.sv
module bridge_cfg_port #(
   parameter int OFF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             wr_i,
   input  logic [OFF_W-1:0] off_i,
   input  logic [1:0]       size_i,
   input  logic [31:0]      wdata_i,
   output logic             done,
   output logic             d_req,
   output logic             d_write,
   output logic [OFF_W-1:0] d_offset,
   output logic [1:0]       d_size,
   output logic [31:0]      d_wdata,
   input  logic             d_ack
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_req    <= 1'b0;
         d_write  <= 1'b0;
         d_offset <= '0;
         d_size   <= 2'd0;
         d_wdata  <= '0;
      end else if (start) begin
         d_req    <= 1'b1;
         d_write  <= wr_i;
         d_offset <= off_i;
         d_size   <= size_i;
         d_wdata  <= wdata_i;
      end else if (d_req && d_ack) begin
         d_req    <= 1'b0;
      end
   end

   assign done = d_req && d_ack;

   // R7: request and its fields hold until the device answers
   p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (d_req && !d_ack) |=> (d_req && $stable(d_offset) && $stable(d_write)
                             && $stable(d_size) && $stable(d_wdata)));

   // R7: only one request outstanding
   p_single_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !d_req);

endmodule

// File: rtl/bridge_regblk.sv
module bridge_regblk
   import bridge_pkg::*;
#(
   parameter int           ADDR_W     = 12,
   parameter int           CFG_BASE   = 'h200,
   parameter int           CFG_SPAN   = 256,
   parameter int           UNLOCK_CYC = 4,
   parameter int           DMA_BYTES  = 32768,
   parameter logic [31:0]  UNLOCK_KEY = 32'h5A14_A501,
   parameter logic [127:0] ID_STR     = "BRIDGE_CFG_ID_01",
   localparam int          CFG_OFF_W  = $clog2(CFG_SPAN)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 h_valid,
   input  logic                 h_write,
   input  logic [ADDR_W-1:0]    h_addr,
   input  logic [1:0]           h_size,
   input  logic [31:0]          h_wdata,
   input  logic [7:0]           h_bus,
   input  logic [7:0]           h_devfn,
   output logic                 h_ack,
   output logic [31:0]          h_rdata,
   output logic                 d_req,
   output logic                 d_write,
   output logic [CFG_OFF_W-1:0] d_offset,
   output logic [1:0]           d_size,
   output logic [31:0]          d_wdata,
   input  logic                 d_ack,
   input  logic [31:0]          d_rdata,
   output logic                 bridge_ready,
   output logic [31:0]          map_win0,
   output logic [31:0]          map_win1,
   output logic [31:0]          dma_base,
   output logic [31:0]          dma_limit,
   output logic                 link_en,
   output logic                 xfer_en
);
   localparam int REG_SPAN = 64;
   localparam int CFG_END  = CFG_BASE + CFG_SPAN;

   // word indices of the software-visible registers
   localparam logic [3:0] IDX_EN_A   = 4'd5;   // 0x14
   localparam logic [3:0] IDX_KEY    = 4'd6;   // 0x18
   localparam logic [3:0] IDX_WIN0   = 4'd8;   // 0x20
   localparam logic [3:0] IDX_WIN1   = 4'd9;   // 0x24
   localparam logic [3:0] IDX_DMA_LO = 4'd10;  // 0x28
   localparam logic [3:0] IDX_DMA_HI = 4'd11;  // 0x2C
   localparam logic [3:0] IDX_EN_B   = 4'd13;  // 0x34

   // elaboration-time parameter checks
   if (ADDR_W < 7 || ADDR_W > 31) begin : g_bad_addr_w
      $error("ADDR_W must lie between 7 and 31");
   end
   if (CFG_SPAN < 4 || (CFG_SPAN & (CFG_SPAN - 1)) != 0) begin : g_bad_span
      $error("CFG_SPAN must be a power of two, at least 4");
   end
   if (CFG_BASE < REG_SPAN || (CFG_BASE % CFG_SPAN) != 0 || CFG_END > (1 << ADDR_W)) begin : g_bad_base
      $error("CFG_BASE must be span-aligned, above the registers and inside the address space");
   end
   if (UNLOCK_CYC < 1) begin : g_bad_unlock
      $error("UNLOCK_CYC must be at least 1");
   end
   if (DMA_BYTES < 1) begin : g_bad_dma
      $error("DMA_BYTES must be positive");
   end

   // address decode
   logic                 in_regs, in_cfg, tgt_sel;
   logic [3:0]           widx;
   logic [1:0]           lane;
   logic [CFG_OFF_W-1:0] cfg_off;

   assign in_regs = (32'(h_addr) < REG_SPAN);
   assign in_cfg  = (32'(h_addr) >= CFG_BASE) && (32'(h_addr) < CFG_END);
   assign tgt_sel = (h_bus == 8'd0) && (h_devfn == 8'd0);
   assign widx    = h_addr[5:2];
   assign lane    = h_addr[1:0];
   assign cfg_off = CFG_OFF_W'(32'(h_addr) - CFG_BASE);

   // acceptance
   logic h_ack_q, busy, acc, fwd, local_acc, fwd_done;
   assign busy      = d_req;
   assign acc       = h_valid && !h_ack_q && !busy;
   assign fwd       = acc && in_cfg && tgt_sel;
   assign local_acc = acc && !(in_cfg && tgt_sel);

   // registers
   logic [31:0] win0_q, win1_q, dma_lo_q, dma_hi_q;
   logic        en_a_q, en_b_q;
   logic        unlocked;
   logic        wr_reg, wr_end;
   logic [32:0] dma_cap;
   logic [31:0] dma_hi_next;

   assign wr_reg      = local_acc && h_write && in_regs;
   assign wr_end      = wr_reg && (widx == IDX_DMA_HI);
   assign dma_cap     = {1'b0, dma_lo_q} + 33'(DMA_BYTES);
   assign dma_hi_next = ({1'b0, h_wdata} > dma_cap) ? dma_cap[31:0] : h_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win0_q   <= '0;
         win1_q   <= '0;
         dma_lo_q <= '0;
         dma_hi_q <= '0;
         en_a_q   <= 1'b0;
         en_b_q   <= 1'b0;
      end else if (wr_reg) begin
         case (widx)
            IDX_EN_A:   en_a_q   <= h_wdata[0];
            IDX_EN_B:   en_b_q   <= h_wdata[0];
            IDX_WIN0:   win0_q   <= h_wdata;
            IDX_WIN1:   win1_q   <= h_wdata;
            IDX_DMA_LO: dma_lo_q <= h_wdata;
            IDX_DMA_HI: dma_hi_q <= dma_hi_next;
            default: ;
         endcase
      end
   end

   // unlock sequencer
   bridge_unlock #(
      .UNLOCK_CYC (UNLOCK_CYC),
      .KEY        (UNLOCK_KEY)
   ) u_unlock (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (wr_reg && (widx == IDX_KEY)),
      .key_data (h_wdata),
      .unlocked (unlocked)
   );

   // identification string
   logic [31:0] id_word;
   bridge_id_rom #(.ID_STR(ID_STR)) u_id (
      .widx (widx[1:0]),
      .word (id_word)
   );

   // register read mux
   logic [31:0] reg_word;
   always_comb begin
      case (widx)
         4'd0, 4'd1, 4'd2, 4'd3: reg_word = id_word;
         IDX_EN_A:               reg_word = {31'd0, en_a_q};
         IDX_KEY:                reg_word = {31'd0, unlocked};
         IDX_WIN0:               reg_word = win0_q;
         IDX_WIN1:               reg_word = win1_q;
         IDX_DMA_LO:             reg_word = dma_lo_q;
         IDX_DMA_HI:             reg_word = dma_hi_q;
         IDX_EN_B:               reg_word = {31'd0, en_b_q};
         default:                reg_word = '0;
      endcase
   end

   logic [31:0] local_rdata;
   always_comb begin
      if (h_write)      local_rdata = '0;
      else if (in_cfg)  local_rdata = width_mask(h_size);
      else if (in_regs) local_rdata = lane_align(reg_word, lane, h_size);
      else              local_rdata = '0;
   end

   // configuration forwarding
   bridge_cfg_port #(.OFF_W(CFG_OFF_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (fwd),
      .wr_i     (h_write),
      .off_i    (cfg_off),
      .size_i   (h_size),
      .wdata_i  (h_wdata),
      .done     (fwd_done),
      .d_req    (d_req),
      .d_write  (d_write),
      .d_offset (d_offset),
      .d_size   (d_size),
      .d_wdata  (d_wdata),
      .d_ack    (d_ack)
   );

   // host response
   logic [31:0] h_rdata_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_ack_q   <= 1'b0;
         h_rdata_q <= '0;
      end else if (fwd_done) begin
         h_ack_q   <= 1'b1;
         h_rdata_q <= d_write ? 32'd0 : (d_rdata & width_mask(d_size));
      end else if (local_acc) begin
         h_ack_q   <= 1'b1;
         h_rdata_q <= local_rdata;
      end else begin
         h_ack_q   <= 1'b0;
      end
   end

   assign h_ack        = h_ack_q;
   assign h_rdata      = h_rdata_q;
   assign bridge_ready = unlocked;
   assign map_win0     = win0_q;
   assign map_win1     = win1_q;
   assign dma_base     = dma_lo_q;
   assign dma_limit    = dma_hi_q;
   assign link_en      = en_a_q;
   assign xfer_en      = en_b_q;

   // R10: acknowledge is a single-cycle pulse
   p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      h_ack |=> !h_ack);

   // R7: host acknowledge follows a device completion by one edge
   p_ack_after_dev_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (d_req && d_ack) |=> h_ack);

   // R8: a device request only starts for bus 0, device/function 0
   p_sel_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(d_req) |-> $past(h_bus == 8'd0 && h_devfn == 8'd0 && h_valid));

   // R5: a write to the DMA end never leaves it beyond the window size
   p_dma_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_end |=> ({1'b0, dma_limit} <= {1'b0, dma_base} + 33'(DMA_BYTES)));

endmodule

// File: tb/sim_bridge_regblk.sv
module sim_bridge_regblk;
   localparam int UNLOCK_CYC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_valid = 1'b0, h_write = 1'b0;
   logic [11:0] h_addr = '0;
   logic [1:0]  h_size = '0;
   logic [31:0] h_wdata = '0;
   logic [7:0]  h_bus = '0, h_devfn = '0;
   logic        h_ack;
   logic [31:0] h_rdata;
   logic        d_req, d_write;
   logic [7:0]  d_offset;
   logic [1:0]  d_size;
   logic [31:0] d_wdata;
   logic        d_ack = 1'b0;
   logic [31:0] d_rdata = '0;
   logic        bridge_ready, link_en, xfer_en;
   logic [31:0] map_win0, map_win1, dma_base, dma_limit;

   always #10 clk = ~clk;   // 50 MHz

   bridge_regblk #(.UNLOCK_CYC(UNLOCK_CYC)) u0 (
      .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_write(h_write),
      .h_addr(h_addr), .h_size(h_size), .h_wdata(h_wdata), .h_bus(h_bus),
      .h_devfn(h_devfn), .h_ack(h_ack), .h_rdata(h_rdata), .d_req(d_req),
      .d_write(d_write), .d_offset(d_offset), .d_size(d_size),
      .d_wdata(d_wdata), .d_ack(d_ack), .d_rdata(d_rdata),
      .bridge_ready(bridge_ready), .map_win0(map_win0), .map_win1(map_win1),
      .dma_base(dma_base), .dma_limit(dma_limit), .link_en(link_en),
      .xfer_en(xfer_en)
   );

   // device model: answers two cycles after a request, records what it saw
   int          nreq = 0;
   int          dwait = 0;
   logic [7:0]  last_off = '0;
   logic [31:0] last_wd = '0;
   logic        last_wr = 1'b0;
   logic [1:0]  last_sz = '0;
   always @(posedge clk) begin
      if (d_ack) begin
         d_ack <= 1'b0;
      end else if (d_req) begin
         if (dwait == 2) begin
            d_ack    <= 1'b1;
            d_rdata  <= 32'hDEAD_BE00 | 32'(d_offset);
            last_off <= d_offset;
            last_wd  <= d_wdata;
            last_wr  <= d_write;
            last_sz  <= d_size;
            nreq     <= nreq + 1;
            dwait    <= 0;
         end else begin
            dwait <= dwait + 1;
         end
      end
   end

   int checks = 0, fails = 0;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic xact(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [7:0] bus,
                       input logic [7:0] devfn, output logic [31:0] rd);
      @(negedge clk);
      h_valid = 1'b1; h_write = wr; h_addr = a; h_size = sz;
      h_wdata = wd; h_bus = bus; h_devfn = devfn;
      rd = 32'hXXXX_XXXX;
      for (int t = 0; t < 50; t++) begin
         @(negedge clk);
         if (h_ack) begin
            rd = h_rdata;
            break;
         end
      end
      h_valid = 1'b0;
   endtask

   typedef struct packed {
      logic        wr;
      logic [11:0] addr;
      logic [1:0]  sz;
      logic [31:0] wd;
      logic [7:0]  bus;
      logic [7:0]  devfn;
      logic [31:0] exp;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 12'h000, 2'd2, 32'h0,        8'd0, 8'd0, 32'h4449_5242, 4'd1},  // R1 word 0
      '{1'b0, 12'h00C, 2'd2, 32'h0,        8'd0, 8'd0, 32'h3130_5F44, 4'd1},  // R1 last word
      '{1'b0, 12'h007, 2'd0, 32'h0,        8'd0, 8'd0, 32'h0000_0043, 4'd1},  // R1 byte lane 3
      '{1'b0, 12'h004, 2'd1, 32'h0,        8'd0, 8'd0, 32'h0000_4547, 4'd1},  // R1 half lane 0
      '{1'b0, 12'h00A, 2'd1, 32'h0,        8'd0, 8'd0, 32'h0000_495F, 4'd1},  // R1 half lane 2
      '{1'b0, 12'h00F, 2'd0, 32'h0,        8'd0, 8'd0, 32'h0000_0031, 4'd1},  // R1 final char
      '{1'b1, 12'h020, 2'd2, 32'h0A0B0C0D, 8'd0, 8'd0, 32'h0,         4'd4},  // R4 write
      '{1'b0, 12'h020, 2'd2, 32'h0,        8'd0, 8'd0, 32'h0A0B_0C0D, 4'd4},  // R4
      '{1'b1, 12'h024, 2'd2, 32'h01000000, 8'd0, 8'd0, 32'h0,         4'd4},  // R4 write
      '{1'b0, 12'h024, 2'd2, 32'h0,        8'd0, 8'd0, 32'h0100_0000, 4'd4},  // R4
      '{1'b0, 12'h024, 2'd1, 32'h0,        8'd0, 8'd0, 32'h0000_0000, 4'd4},  // R4 low half
      '{1'b1, 12'h028, 2'd2, 32'h01840000, 8'd0, 8'd0, 32'h0,         4'd5},  // R5 start
      '{1'b1, 12'h02C, 2'd2, 32'h01848000, 8'd0, 8'd0, 32'h0,         4'd5},  // R5 end at cap
      '{1'b0, 12'h02C, 2'd2, 32'h0,        8'd0, 8'd0, 32'h0184_8000, 4'd5},  // R5
      '{1'b1, 12'h02C, 2'd2, 32'h01850000, 8'd0, 8'd0, 32'h0,         4'd5},  // R5 beyond cap
      '{1'b0, 12'h02C, 2'd2, 32'h0,        8'd0, 8'd0, 32'h0184_8000, 4'd5},  // R5 clamped
      '{1'b0, 12'h028, 2'd2, 32'h0,        8'd0, 8'd0, 32'h0184_0000, 4'd5},  // R5
      '{1'b1, 12'h014, 2'd2, 32'hFFFFFFFF, 8'd0, 8'd0, 32'h0,         4'd6},  // R6
      '{1'b0, 12'h014, 2'd2, 32'h0,        8'd0, 8'd0, 32'h0000_0001, 4'd6},  // R6 bit 0 only
      '{1'b1, 12'h034, 2'd2, 32'h00000002, 8'd0, 8'd0, 32'h0,         4'd6},  // R6
      '{1'b0, 12'h034, 2'd2, 32'h0,        8'd0, 8'd0, 32'h0000_0000, 4'd6},  // R6
      '{1'b0, 12'h01C, 2'd2, 32'h0,        8'd0, 8'd0, 32'h0000_0000, 4'd10}, // R10 hole
      '{1'b0, 12'h100, 2'd2, 32'h0,        8'd0, 8'd0, 32'h0000_0000, 4'd10}, // R10 unmapped
      '{1'b0, 12'h210, 2'd2, 32'h0,        8'd1, 8'd0, 32'hFFFF_FFFF, 4'd8},  // R8 word
      '{1'b0, 12'h211, 2'd0, 32'h0,        8'd0, 8'd8, 32'h0000_00FF, 4'd8},  // R8 byte
      '{1'b0, 12'h212, 2'd1, 32'h0,        8'd0, 8'd1, 32'h0000_FFFF, 4'd8},  // R8 half
      '{1'b0, 12'h018, 2'd2, 32'h0,        8'd0, 8'd0, 32'h0000_0000, 4'd2},  // R2 locked
      '{1'b1, 12'h018, 2'd2, 32'h12345678, 8'd0, 8'd0, 32'h0,         4'd2},  // R2 wrong key
      '{1'b0, 12'h018, 2'd2, 32'h0,        8'd0, 8'd0, 32'h0000_0000, 4'd2}   // R2 still locked
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R3, R4, R5, R6, R7, R10)
      chk("R3 ready after reset", 32'(bridge_ready), 32'd0);
      chk("R4 win0 after reset", map_win0, 32'd0);
      chk("R5 dma_limit after reset", dma_limit, 32'd0);
      chk("R6 enables after reset", {30'd0, link_en, xfer_en}, 32'd0);
      chk("R7 d_req after reset", 32'(d_req), 32'd0);
      chk("R10 h_ack after reset", 32'(h_ack), 32'd0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         xact(VECS[i].wr, VECS[i].addr, VECS[i].sz, VECS[i].wd,
              VECS[i].bus, VECS[i].devfn, rd);
         chk($sformatf("R%0d vector %0d", VECS[i].rq, i), rd, VECS[i].exp);
      end
      chk("R4 map_win0 port", map_win0, 32'h0A0B_0C0D);
      chk("R5 dma_limit port", dma_limit, 32'h0184_8000);
      chk("R6 link_en/xfer_en ports", {30'd0, link_en, xfer_en}, 32'd2);
      chk("R8 no device request for other targets", 32'(nreq), 32'd0);
      chk("R2 ready low after wrong key", 32'(bridge_ready), 32'd0);

      // R3: exact unlock delay
      xact(1'b1, 12'h018, 2'd2, 32'h5A14_A501, 8'd0, 8'd0, rd);
      for (int k = 1; k < UNLOCK_CYC; k++) begin
         @(posedge clk); @(negedge clk);
         chk($sformatf("R3 ready low %0d edges after key", k), 32'(bridge_ready), 32'd0);
      end
      @(posedge clk); @(negedge clk);
      chk("R3 ready high at delay", 32'(bridge_ready), 32'd1);
      xact(1'b0, 12'h018, 2'd2, 32'h0, 8'd0, 8'd0, rd);
      chk("R3 status reads 1", rd, 32'd1);
      xact(1'b1, 12'h018, 2'd2, 32'h0, 8'd0, 8'd0, rd);
      xact(1'b0, 12'h018, 2'd2, 32'h0, 8'd0, 8'd0, rd);
      chk("R3 status stays 1", rd, 32'd1);

      // R7: forwarded accesses
      xact(1'b0, 12'h210, 2'd0, 32'h0, 8'd0, 8'd0, rd);
      chk("R7 byte read data", rd, 32'h0000_0010);
      chk("R7 byte read offset", 32'(last_off), 32'h10);
      xact(1'b0, 12'h2FC, 2'd2, 32'h0, 8'd0, 8'd0, rd);
      chk("R7 word read data", rd, 32'hDEAD_BEFC);
      xact(1'b1, 12'h204, 2'd1, 32'h0000_1234, 8'd0, 8'd0, rd);
      chk("R7 write returns 0", rd, 32'd0);
      chk("R7 write fields", {last_wd[15:0], 6'd0, last_sz, 7'd0, last_wr}, {16'h1234, 6'd0, 2'd1, 7'd0, 1'b1});
      chk("R7 write offset", 32'(last_off), 32'h04);
      chk("R7 request count", 32'(nreq), 32'd3);

      // R9: unselected write discarded
      xact(1'b1, 12'h208, 2'd2, 32'hCAFE_F00D, 8'd0, 8'd3, rd);
      chk("R9 no request for other target", 32'(nreq), 32'd3);
      chk("R9 device state untouched", last_wd, 32'h0000_1234);
      xact(1'b0, 12'h208, 2'd1, 32'h0, 8'd2, 8'd0, rd);
      chk("R8 half read other bus", rd, 32'h0000_FFFF);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule